// File: doc/BRIEF.md
# Buck Controller Startup and Over-Voltage Sequencer

This block is the digital sequencer that brings a synchronous buck controller from power-up to regulation and shuts it down safely on an output over-voltage. It watches two supply comparator flags with hysteresis, the enable pin, a flag saying the voltage-select code is usable, an over-voltage comparator flag and a tick from the switching oscillator. From these it decides when the gate drivers may run, produces a rising ramp code that limits the error-amplifier output during soft start, holds power-good low whenever the output is not yet trusted, and forces the high-side gate off and the low-side gate on after a fault.

The soft-start interval is counted in switching ticks, not in system clocks, so its length tracks the chosen switching frequency. Once the output has been regulated, an over-voltage event latches a protection state. The comparator falling back does not release it. Only a drop of enable, a loss of the code (the all-ones shutdown code reaches this block as the valid flag going low), or a supply dip releases it. Every release goes back through a full soft start.

Top module: `buck_start_seq`

## Requirements
- R1: The sequencer leaves its power-on reset state only when `vccHigh` is 1. From any state, `vccOk` at 0 returns it to reset on the next clock. While `vccOk` is 1 and `vccHigh` is 0, the current state is kept.
- R2: In reset and in idle, `drvEnable`, `forceHsOff`, `forceLsOn` and `ssActive` are 0, `pgoodForceLow` is 1 and `rampCode` is 0.
- R3: From idle, soft start begins on the clock after `enable` and `codeValid` are both 1. `ssActive` and `drvEnable` go to 1, and `rampCode` starts at 0.
- R4: Soft start lasts exactly 2^SS_LOG2 `swTick` pulses (2048 by default). `rampCode` equals the top RAMP_W bits of the SS_LOG2-bit tick count (count >> 5 with the defaults). Clocks without `swTick` do not advance it.
- R5: In run, `ssActive` and `pgoodForceLow` are 0, `drvEnable` is 1, and `rampCode` sits at full scale (all ones).
- R6: `ovpTrip` has no effect outside run. In particular it does not interrupt or shorten soft start.
- R7: `ovpTrip` at 1 in run enters protection on the next clock. In protection, `forceHsOff`, `forceLsOn`, `drvEnable` and `pgoodForceLow` are 1. The state is held after `ovpTrip` returns to 0.
- R8: Protection is released only by `enable` at 0 or `codeValid` at 0 (both go to idle) or by `vccOk` at 0 (goes to reset). The next start always runs a full soft start from ramp 0.
- R9: `enable` at 0 in soft start, run or protection sends the sequencer to idle on the next clock, with `drvEnable` at 0.
- R10: In run, `enable` or `codeValid` at 0 takes priority over a simultaneous `ovpTrip`, and the sequencer goes to idle rather than protection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| vccHigh | input | 1 | Supply is above the rising (release) threshold |
| vccOk | input | 1 | Supply is above the falling (re-reset) threshold |
| enable | input | 1 | Output enable pin level |
| codeValid | input | 1 | Voltage-select code is usable (low for shutdown code) |
| ovpTrip | input | 1 | Output is above the over-voltage limit |
| swTick | input | 1 | One-clock pulse per switching period |
| drvEnable | output | 1 | Gate drivers may switch |
| rampCode | output | RAMP_W | Soft-start limit code for the error-amplifier clamp |
| ssActive | output | 1 | Soft start in progress |
| pgoodForceLow | output | 1 | Power-good must be held low |
| forceHsOff | output | 1 | Hold the high-side gate off |
| forceLsOn | output | 1 | Hold the low-side gate on |

## Verification
The hardest condition to reach is the protection latch, and each of its three release paths. The stimulus can only get there after a complete soft start of 2048 ticks followed by an over-voltage pulse in run. The bench therefore uses a directed soft-start routine that counts the ticks itself, pauses the tick stream partway to show that the count holds, and optionally keeps `ovpTrip` high during the ramp. It then enters protection, drops `ovpTrip`, and releases the latch through enable, code loss and supply loss in turn, each time re-running the whole ramp.

// File: rtl/bss_pkg.sv
package bss_pkg;

  typedef enum logic [2:0] {
    ST_RESET = 3'd0,
    ST_IDLE  = 3'd1,
    ST_SOFT  = 3'd2,
    ST_RUN   = 3'd3,
    ST_OVP   = 3'd4
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClear;   // hold the tick counter at zero
    logic cntStep;    // count swTick pulses
    logic rampFull;   // ramp code at full scale
    logic drvOn;      // gate drivers allowed
    logic faultHold;  // low-side on, high-side off
    logic softOn;     // soft start in progress
    logic pgLow;      // power-good forced low
  } seqStrobe_t;

endpackage

// File: rtl/bss_ctrl.sv
module bss_ctrl
  import bss_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       vccHigh,
  input  logic       vccOk,
  input  logic       enable,
  input  logic       codeValid,
  input  logic       ovpTrip,
  input  logic       swTick,
  input  logic       cntDone,
  output seqStrobe_t strobe
);

  seqState_t stateQ;
  seqState_t stateD;
  logic      goAllowed;

  assign goAllowed = enable && codeValid;

  always_comb begin
    stateD = stateQ;
    if (!vccOk) begin
      stateD = ST_RESET;
    end else begin
      case (stateQ)
        ST_RESET: if (vccHigh) stateD = ST_IDLE;
        ST_IDLE:  if (goAllowed) stateD = ST_SOFT;
        ST_SOFT: begin
          if (!goAllowed)             stateD = ST_IDLE;
          else if (swTick && cntDone) stateD = ST_RUN;
        end
        ST_RUN: begin
          if (!goAllowed)   stateD = ST_IDLE;
          else if (ovpTrip) stateD = ST_OVP;
        end
        ST_OVP:   if (!goAllowed) stateD = ST_IDLE;
        default:  stateD = ST_RESET;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_RESET;
    else       stateQ <= stateD;
  end

  always_comb begin
    strobe.cntClear  = (stateQ != ST_SOFT);
    strobe.cntStep   = (stateQ == ST_SOFT);
    strobe.rampFull  = (stateQ == ST_RUN);
    strobe.drvOn     = (stateQ == ST_SOFT) || (stateQ == ST_RUN) || (stateQ == ST_OVP);
    strobe.faultHold = (stateQ == ST_OVP);
    strobe.softOn    = (stateQ == ST_SOFT);
    strobe.pgLow     = (stateQ != ST_RUN);
  end

endmodule

// File: rtl/bss_dpath.sv
module bss_dpath
  import bss_pkg::*;
#(
  parameter int SS_LOG2 = 11,
  parameter int RAMP_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              swTick,
  input  seqStrobe_t        strobe,
  output logic              cntDone,
  output logic              drvEnable,
  output logic [RAMP_W-1:0] rampCode,
  output logic              ssActive,
  output logic              pgoodForceLow,
  output logic              forceHsOff,
  output logic              forceLsOn
);

  localparam int CNT_W = SS_LOG2;
  localparam logic [CNT_W-1:0] CNT_LAST = {CNT_W{1'b1}};

  logic [CNT_W-1:0]  tickCnt;
  logic [RAMP_W-1:0] softRamp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          tickCnt <= '0;
    else if (strobe.cntClear)           tickCnt <= '0;
    else if (strobe.cntStep && swTick)  tickCnt <= tickCnt + 1'b1;
  end

  assign cntDone = (tickCnt == CNT_LAST);

  generate
    if (RAMP_W <= CNT_W) begin : g_slice
      assign softRamp = tickCnt[CNT_W-1 -: RAMP_W];
    end else begin : g_pad
      assign softRamp = {tickCnt, {(RAMP_W-CNT_W){1'b0}}};
    end
  endgenerate

  always_comb begin
    if (strobe.rampFull)    rampCode = '1;
    else if (strobe.softOn) rampCode = softRamp;
    else                    rampCode = '0;
  end

  assign drvEnable     = strobe.drvOn;
  assign ssActive      = strobe.softOn;
  assign pgoodForceLow = strobe.pgLow;
  assign forceHsOff    = strobe.faultHold;
  assign forceLsOn     = strobe.faultHold;

endmodule

// File: rtl/buck_start_seq.sv
module buck_start_seq
  import bss_pkg::*;
#(
  parameter int SS_LOG2 = 11,
  parameter int RAMP_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              vccHigh,
  input  logic              vccOk,
  input  logic              enable,
  input  logic              codeValid,
  input  logic              ovpTrip,
  input  logic              swTick,
  output logic              drvEnable,
  output logic [RAMP_W-1:0] rampCode,
  output logic              ssActive,
  output logic              pgoodForceLow,
  output logic              forceHsOff,
  output logic              forceLsOn
);

  seqStrobe_t strobe;
  logic       cntDone;

  bss_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .vccHigh   (vccHigh),
    .vccOk     (vccOk),
    .enable    (enable),
    .codeValid (codeValid),
    .ovpTrip   (ovpTrip),
    .swTick    (swTick),
    .cntDone   (cntDone),
    .strobe    (strobe)
  );

  bss_dpath #(
    .SS_LOG2 (SS_LOG2),
    .RAMP_W  (RAMP_W)
  ) u_dpath (
    .clk           (clk),
    .rstN          (rstN),
    .swTick        (swTick),
    .strobe        (strobe),
    .cntDone       (cntDone),
    .drvEnable     (drvEnable),
    .rampCode      (rampCode),
    .ssActive      (ssActive),
    .pgoodForceLow (pgoodForceLow),
    .forceHsOff    (forceHsOff),
    .forceLsOn     (forceLsOn)
  );

endmodule

// File: rtl/bss_chk.sv
module bss_chk #(
  parameter int RAMP_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              vccOk,
  input logic              enable,
  input logic              codeValid,
  input logic              ovpTrip,
  input logic              drvEnable,
  input logic [RAMP_W-1:0] rampCode,
  input logic              ssActive,
  input logic              pgoodForceLow,
  input logic              forceHsOff,
  input logic              forceLsOn
);

  AST_SUPPLY_LOSS_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !vccOk |=> (!drvEnable && rampCode == '0 && !forceLsOn)); // R1

  AST_DISABLE_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !drvEnable); // R9

  AST_RAMP_RISES: assert property (@(posedge clk) disable iff (!rstN)
    (ssActive && $past(ssActive)) |-> (rampCode >= $past(rampCode))); // R4

  AST_SOFT_NO_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    (ssActive && vccOk) |=> !forceLsOn); // R6

  AST_RUN_FULL_RAMP: assert property (@(posedge clk) disable iff (!rstN)
    !pgoodForceLow |-> (rampCode == '1 && drvEnable)); // R5

  AST_FAULT_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(forceLsOn) |-> $past(ovpTrip)); // R7

  AST_FAULT_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    (forceLsOn && enable && codeValid && vccOk) |=> (forceLsOn && forceHsOff && pgoodForceLow)); // R8

endmodule

bind buck_start_seq bss_chk #(.RAMP_W(RAMP_W)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .vccOk         (vccOk),
  .enable        (enable),
  .codeValid     (codeValid),
  .ovpTrip       (ovpTrip),
  .drvEnable     (drvEnable),
  .rampCode      (rampCode),
  .ssActive      (ssActive),
  .pgoodForceLow (pgoodForceLow),
  .forceHsOff    (forceHsOff),
  .forceLsOn     (forceLsOn)
);

// File: tb/sim_buck_start_seq.sv
`timescale 1ns/1ps
module sim_buck_start_seq;

  localparam int SS_LOG2 = 11;
  localparam int RAMP_W  = 6;
  localparam int SS_LEN  = 1 << SS_LOG2;
  localparam int SHIFT   = SS_LOG2 - RAMP_W;
  localparam int RAMP_MAX = (1 << RAMP_W) - 1;

  // expected output packing: {drv, hsOff, lsOn, ss, pgLow}
  localparam logic [4:0] O_OFF  = 5'b00001;
  localparam logic [4:0] O_SOFT = 5'b10011;
  localparam logic [4:0] O_RUN  = 5'b10000;
  localparam logic [4:0] O_OVP  = 5'b11101;

  // row: {vccHigh, vccOk, enable, codeValid, ovpTrip, swTick, expected[4:0]}
  localparam int NROWS = 14;
  localparam logic [10:0] VEC [NROWS] = '{
    {6'b010000, O_OFF},   // vccOk only: still reset (R1)
    {6'b110100, O_OFF},   // vccHigh: idle, enable low (R2)
    {6'b010100, O_OFF},   // between thresholds: idle held (R1)
    {6'b011000, O_OFF},   // code invalid: no start (R3)
    {6'b011100, O_SOFT},  // start (R3)
    {6'b011111, O_SOFT},  // ovp during soft start ignored (R6)
    {6'b010101, O_OFF},   // enable low: idle (R9)
    {6'b011100, O_SOFT},  // restart (R3)
    {6'b011100, O_SOFT},
    {6'b001100, O_OFF},   // supply loss: reset (R1)
    {6'b011100, O_OFF},   // vccOk back but not high: reset held (R1)
    {6'b111100, O_OFF},   // released to idle (R1)
    {6'b111100, O_SOFT},  // then soft start (R3)
    {6'b111000, O_OFF}    // code lost: idle (R2)
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic vccHigh = 1'b0, vccOk = 1'b0, enable = 1'b0, codeValid = 1'b0;
  logic ovpTrip = 1'b0, swTick = 1'b0;
  logic drvEnable, ssActive, pgoodForceLow, forceHsOff, forceLsOn;
  logic [RAMP_W-1:0] rampCode;

  int nChk = 0;
  int nBad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  buck_start_seq #(.SS_LOG2(SS_LOG2), .RAMP_W(RAMP_W)) u0 (
    .clk(clk), .rstN(rstN), .vccHigh(vccHigh), .vccOk(vccOk),
    .enable(enable), .codeValid(codeValid), .ovpTrip(ovpTrip), .swTick(swTick),
    .drvEnable(drvEnable), .rampCode(rampCode), .ssActive(ssActive),
    .pgoodForceLow(pgoodForceLow), .forceHsOff(forceHsOff), .forceLsOn(forceLsOn)
  );

  function automatic logic [4:0] outs();
    return {drvEnable, forceHsOff, forceLsOn, ssActive, pgoodForceLow};
  endfunction

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  // enters with sequencer in soft start at count 0; leaves it in run
  task automatic softStart(input string tag, input bit ovpDuring);
    ovpTrip = ovpDuring;
    for (int i = 1; i < SS_LEN; i++) begin
      swTick = 1'b1;
      cyc();
      if (i == 32)  check({"R4 ramp after 32 ticks ", tag}, rampCode, 32 >> SHIFT);
      if (i == 100) begin
        swTick = 1'b0;
        cyc();
        check({"R4 ramp holds without tick ", tag}, rampCode, 100 >> SHIFT);
      end
    end
    check({"R6 still soft after 2047 ticks ", tag}, outs(), O_SOFT);
    check({"R4 ramp at last soft tick ", tag}, rampCode, RAMP_MAX);
    ovpTrip = 1'b0;
    swTick = 1'b1;
    cyc();
    swTick = 1'b0;
    check({"R5 run outputs ", tag}, outs(), O_RUN);
    check({"R5 run ramp full ", tag}, rampCode, RAMP_MAX);
  endtask

  task automatic tripOvp(input string tag);
    ovpTrip = 1'b1;
    cyc();
    check({"R7 protection entry ", tag}, outs(), O_OVP);
    ovpTrip = 1'b0;
    repeat (4) cyc();
    check({"R7 protection latched ", tag}, outs(), O_OVP);
  endtask

  initial begin
    repeat (3) cyc();
    check("R2 reset outputs", outs(), O_OFF);
    check("R2 reset ramp", rampCode, 0);
    rstN = 1'b1;

    for (int r = 0; r < NROWS; r++) begin
      {vccHigh, vccOk, enable, codeValid, ovpTrip, swTick} = VEC[r][10:5];
      cyc();
      check($sformatf("table row %0d (R1 R2 R3 R6 R9)", r), outs(), VEC[r][4:0]);
      check($sformatf("table row %0d ramp (R2 R3)", r), rampCode, 0);
    end
    ovpTrip = 1'b0;
    swTick = 1'b0;

    // first full start, with ovp held high during the ramp
    codeValid = 1'b1;
    cyc();
    check("R3 soft entry", outs(), O_SOFT);
    softStart("first", 1'b1);
    tripOvp("first");
    vccHigh = 1'b0;
    cyc();
    check("R1 protection kept between thresholds", outs(), O_OVP);

    // release by enable toggle
    enable = 1'b0;
    cyc();
    check("R8 enable low releases", outs(), O_OFF);
    enable = 1'b1;
    cyc();
    check("R8 restart soft after enable", outs(), O_SOFT);
    check("R8 ramp restarts at zero", rampCode, 0);
    softStart("second", 1'b0);
    tripOvp("second");

    // release by shutdown code
    codeValid = 1'b0;
    cyc();
    check("R8 code loss releases", outs(), O_OFF);
    codeValid = 1'b1;
    cyc();
    check("R8 restart soft after code", outs(), O_SOFT);
    softStart("third", 1'b0);
    tripOvp("third");

    // release by supply cycle
    vccOk = 1'b0;
    cyc();
    check("R8 supply loss releases", outs(), O_OFF);
    vccOk = 1'b1;
    cyc();
    check("R1 reset held below rising threshold", outs(), O_OFF);
    vccHigh = 1'b1;
    cyc();
    check("R1 reset released to idle", outs(), O_OFF);
    cyc();
    check("R8 restart soft after supply", outs(), O_SOFT);
    softStart("fourth", 1'b0);

    // disable beats simultaneous ovp in run
    ovpTrip = 1'b1;
    enable = 1'b0;
    cyc();
    check("R10 disable wins over ovp", outs(), O_OFF);
    ovpTrip = 1'b0;
    cyc();
    check("R9 stays idle while disabled", outs(), O_OFF);

    finished = 1'b1;
    finish();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish();
    end
  end

endmodule